// File: doc/BRIEF.md
# Direct-Page Bit Test and Set Sequencer

This block is the execution sequencer of an 8-bit accumulator processor for three bit-oriented instructions. The first sets one bit of a byte in the direct page, which is the lowest 256 bytes of the address space. The second branches when one bit of such a byte is 1. The third branches when that bit is 0. The bit number is carried inside the opcode. The sequencer walks a fixed five-cycle bus pattern and reports the program counter at which execution continues.

The surrounding fetch logic hands over the opcode, the direct address byte (already sitting in the prefetch queue) and the address of the opcode, all on a single `start` cycle. From then on the block drives every bus cycle itself. For the branch forms, it reads the data byte and then performs four program fetches: the relative offset, the byte after it, and two bytes at the continuation address. For the set form, it reads the byte, leaves one bus cycle unused, writes the modified byte back, and then fetches the two bytes that follow the instruction. Data returned by the bus is sampled at the end of the cycle that requested it.

Top module: `dbit_seq`

## Requirements
- R1: After reset, `busy` and `done` are 0 and `bus_kind` is 0 (free). Whenever `busy` is 0, `bus_kind` stays 0.
- R2: On a `start` cycle with `busy` at 0, the opcode is decoded as follows. Opcode `{4'b0000, n[2:0], 1'b0}` is branch-if-bit-set. Opcode `{4'b0000, n, 1'b1}` is branch-if-bit-clear. Opcode `{4'b0001, n, 1'b0}` is set-bit. Here n is the bit number. Any other opcode is ignored: `busy` stays 0 and no bus cycle is started.
- R3: A branch form produces this `bus_kind` sequence over the five cycles after acceptance: 1 (data read), then 3, 3, 3, 3 (program fetch). The addresses are `{8'h00, dir_addr}`, then P+2, P+3, T, T+1. P is `op_pc` and T is the continuation address.
- R4: The set-bit form produces the `bus_kind` sequence 1, 0 (free), 2 (write), 3, 3. The addresses are `{8'h00, dir_addr}` for both the read and the write, then P+2 and P+3.
- R5: The byte driven on `bus_wdata` during the write cycle equals the byte read in the read cycle with bit n forced to 1. The other bits are unchanged.
- R6: A branch is taken when bit n of the read byte is 1 (set form) or 0 (clear form). If taken, T = P + 3 + the sign-extended offset byte, which is the `bus_rdata` value sampled in the cycle after the read. If not taken, T = P + 3. All sums wrap at 16 bits.
- R7: For the set-bit form, the continuation address is P + 2.
- R8: `busy` is 1 for exactly five cycles per accepted instruction. `done` is 1 only in the fifth of them, and `next_pc` holds the continuation address in that cycle.
- R9: `start` is ignored while `busy` is 1. A `start` raised mid-instruction changes neither the remaining bus pattern nor the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Instruction hand-over strobe |
| opcode | input | 8 | Opcode of the instruction |
| dir_addr | input | 8 | Direct-page address byte |
| op_pc | input | 16 | Address of the opcode |
| bus_rdata | input | 8 | Byte returned by the current bus cycle |
| bus_kind | output | 2 | Cycle type: 0 free, 1 read, 2 write, 3 program fetch |
| bus_addr | output | 16 | Bus address of the current cycle |
| bus_wdata | output | 8 | Write data, valid in write cycles, 0 otherwise |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | Final cycle of the instruction |
| next_pc | output | 16 | Continuation address, valid with `done` |

## Verification
The bench builds the block with its default parameters: a 16-bit address, an 8-bit data byte and the opcode bases 0x00 and 0x10. With these values, all eight bit positions and all three instruction forms can be reached from plain byte stimulus. The 16-bit width lets an opcode placed near 0xFFFF show wrap-around of both the fetch addresses and the branch target. The full signed offset range from -128 to +127 is driven directly, so both extremes of the sign extension are checked against the continuation address.

// File: rtl/dbit_pkg.sv
package dbit_pkg;

   typedef enum logic [1:0] {
      CYC_FREE  = 2'd0,
      CYC_READ  = 2'd1,
      CYC_WRITE = 2'd2,
      CYC_FETCH = 2'd3
   } cyc_e;

   typedef enum logic [1:0] {
      OPK_NONE    = 2'd0,
      OPK_BR_ONE  = 2'd1,
      OPK_BR_ZERO = 2'd2,
      OPK_SET     = 2'd3
   } opk_e;

   // address source of the current bus cycle
   typedef enum logic [1:0] {
      ASEL_DIR  = 2'd0,
      ASEL_OPND = 2'd1,
      ASEL_NEXT = 2'd2
   } asel_e;

   localparam int SEQ_STEPS = 5;

endpackage

// File: rtl/dbit_decode.sv
module dbit_decode
   import dbit_pkg::*;
#(
   parameter int              OP_W     = 8,
   parameter int              DATA_W   = 8,
   parameter logic [OP_W-1:0] BR_BASE  = 8'h00,
   parameter logic [OP_W-1:0] SET_BASE = 8'h10,
   localparam int             BIT_W    = $clog2(DATA_W)
) (
   input  logic [OP_W-1:0]   opcode,
   output opk_e              kind,
   output logic [DATA_W-1:0] mask
);

   localparam int GRP_LO = BIT_W + 1;

   generate
      if ((1 << BIT_W) != DATA_W) begin : g_bad_width
         $error("dbit_decode: DATA_W must be a power of two");
      end
      if (GRP_LO >= OP_W) begin : g_bad_op
         $error("dbit_decode: opcode too narrow for bit field");
      end
      if (BR_BASE[GRP_LO-1:0] != '0 || SET_BASE[GRP_LO-1:0] != '0) begin : g_bad_base
         $error("dbit_decode: opcode bases must be aligned to the bit field");
      end
      if (BR_BASE[OP_W-1:GRP_LO] == SET_BASE[OP_W-1:GRP_LO]) begin : g_bad_overlap
         $error("dbit_decode: opcode groups overlap");
      end
   endgenerate

   logic [OP_W-GRP_LO-1:0] grp;
   logic [BIT_W-1:0]       bsel;
   logic                   pol;

   assign grp  = opcode[OP_W-1:GRP_LO];
   assign bsel = opcode[BIT_W:1];
   assign pol  = opcode[0];

   always_comb begin
      kind = OPK_NONE;
      if (grp == BR_BASE[OP_W-1:GRP_LO]) begin
         kind = pol ? OPK_BR_ZERO : OPK_BR_ONE;
      end else if (grp == SET_BASE[OP_W-1:GRP_LO] && !pol) begin
         kind = OPK_SET;
      end
   end

   for (genvar i = 0; i < DATA_W; i++) begin : g_mask
      assign mask[i] = (bsel == BIT_W'(i));
   end

endmodule

// File: rtl/dbit_ctrl.sv
module dbit_ctrl
   import dbit_pkg::*;
#(
   parameter int  STEP_N = SEQ_STEPS,
   localparam int SW     = $clog2(STEP_N)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          launch,
   input  opk_e          kind_in,
   output logic          busy,
   output opk_e          kind_q,
   output cyc_e          cyc,
   output asel_e         asel,
   output logic          plus1,
   output logic          last,
   output logic          cap_data,
   output logic          cap_off
);

   generate
      if (STEP_N != 5) begin : g_bad_steps
         $error("dbit_ctrl: bus pattern is defined for five cycles only");
      end
   endgenerate

   logic [SW-1:0] step;
   logic          is_br;

   assign is_br = (kind_q == OPK_BR_ONE) || (kind_q == OPK_BR_ZERO);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy   <= 1'b0;
         step   <= '0;
         kind_q <= OPK_NONE;
      end else if (!busy) begin
         if (launch) begin
            busy   <= 1'b1;
            step   <= '0;
            kind_q <= kind_in;
         end
      end else if (last) begin
         busy <= 1'b0;
         step <= '0;
      end else begin
         step <= step + SW'(1);
      end
   end

   always_comb begin
      cyc   = CYC_FREE;
      asel  = ASEL_DIR;
      plus1 = 1'b0;
      if (busy) begin
         case (step)
            SW'(0): cyc = CYC_READ;
            SW'(1): begin
               if (is_br) begin
                  cyc  = CYC_FETCH;
                  asel = ASEL_OPND;
               end
            end
            SW'(2): begin
               if (is_br) begin
                  cyc   = CYC_FETCH;
                  asel  = ASEL_OPND;
                  plus1 = 1'b1;
               end else begin
                  cyc = CYC_WRITE;
               end
            end
            SW'(3): begin
               cyc  = CYC_FETCH;
               asel = ASEL_NEXT;
            end
            default: begin
               cyc   = CYC_FETCH;
               asel  = ASEL_NEXT;
               plus1 = 1'b1;
            end
         endcase
      end
   end

   assign last     = busy && (step == SW'(STEP_N - 1));
   assign cap_data = busy && (step == SW'(0));
   assign cap_off  = busy && (step == SW'(1)) && is_br;

endmodule

// File: rtl/dbit_pc.sv
module dbit_pc
   import dbit_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              launch,
   input  logic [ADDR_W-1:0] op_pc,
   input  logic              cap_off,
   input  logic [DATA_W-1:0] off_in,
   input  opk_e              kind_q,
   input  logic              bit_val,
   input  asel_e             asel,
   input  logic              plus1,
   output logic [ADDR_W-1:0] addr_pc,
   output logic [ADDR_W-1:0] next_pc
);

   logic [ADDR_W-1:0] pc_q;
   logic [DATA_W-1:0] off_q;
   logic [ADDR_W-1:0] rel_ext;
   logic [ADDR_W-1:0] seq2, seq3, base;
   logic              taken;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pc_q  <= '0;
         off_q <= '0;
      end else begin
         if (launch)  pc_q  <= op_pc;
         if (cap_off) off_q <= off_in;
      end
   end

   generate
      if (ADDR_W > DATA_W) begin : g_sext
         assign rel_ext = {{(ADDR_W-DATA_W){off_q[DATA_W-1]}}, off_q};
      end else begin : g_trunc
         assign rel_ext = off_q[ADDR_W-1:0];
      end
   endgenerate

   assign seq2  = pc_q + ADDR_W'(2);
   assign seq3  = pc_q + ADDR_W'(3);
   assign taken = (kind_q == OPK_BR_ONE  &&  bit_val) ||
                  (kind_q == OPK_BR_ZERO && !bit_val);

   always_comb begin
      if (kind_q == OPK_SET) next_pc = seq2;
      else if (taken)        next_pc = seq3 + rel_ext;
      else                   next_pc = seq3;
   end

   assign base    = (asel == ASEL_OPND) ? seq2 : next_pc;
   assign addr_pc = base + {{(ADDR_W-1){1'b0}}, plus1};

endmodule

// File: rtl/dbit_seq.sv
module dbit_seq
   import dbit_pkg::*;
#(
   parameter int              ADDR_W   = 16,
   parameter int              DATA_W   = 8,
   parameter int              OP_W     = 8,
   parameter logic [OP_W-1:0] BR_BASE  = 8'h00,
   parameter logic [OP_W-1:0] SET_BASE = 8'h10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [OP_W-1:0]   opcode,
   input  logic [DATA_W-1:0] dir_addr,
   input  logic [ADDR_W-1:0] op_pc,
   input  logic [DATA_W-1:0] bus_rdata,
   output logic [1:0]        bus_kind,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [DATA_W-1:0] bus_wdata,
   output logic              busy,
   output logic              done,
   output logic [ADDR_W-1:0] next_pc
);

   generate
      if (ADDR_W <= DATA_W) begin : g_bad_addr
         $error("dbit_seq: address must be wider than the direct-page byte");
      end
   endgenerate

   opk_e              dec_kind, kind_q;
   logic [DATA_W-1:0] dec_mask;
   logic              launch;
   cyc_e              cyc;
   asel_e             asel;
   logic              plus1, last, cap_data, cap_off;
   logic [DATA_W-1:0] dir_q, data_q, mask_q;
   logic [ADDR_W-1:0] addr_pc;
   logic              bit_val;

   dbit_decode #(
      .OP_W    (OP_W),
      .DATA_W  (DATA_W),
      .BR_BASE (BR_BASE),
      .SET_BASE(SET_BASE)
   ) dec_i (
      .opcode(opcode),
      .kind  (dec_kind),
      .mask  (dec_mask)
   );

   assign launch = start && !busy && (dec_kind != OPK_NONE);

   dbit_ctrl #(.STEP_N(SEQ_STEPS)) ctrl_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .launch  (launch),
      .kind_in (dec_kind),
      .busy    (busy),
      .kind_q  (kind_q),
      .cyc     (cyc),
      .asel    (asel),
      .plus1   (plus1),
      .last    (last),
      .cap_data(cap_data),
      .cap_off (cap_off)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dir_q  <= '0;
         mask_q <= '0;
         data_q <= '0;
      end else begin
         if (launch) begin
            dir_q  <= dir_addr;
            mask_q <= dec_mask;
         end
         if (cap_data) data_q <= bus_rdata;
      end
   end

   assign bit_val = |(data_q & mask_q);

   dbit_pc #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) pc_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .launch (launch),
      .op_pc  (op_pc),
      .cap_off(cap_off),
      .off_in (bus_rdata),
      .kind_q (kind_q),
      .bit_val(bit_val),
      .asel   (asel),
      .plus1  (plus1),
      .addr_pc(addr_pc),
      .next_pc(next_pc)
   );

   assign bus_kind  = cyc;
   assign bus_addr  = (asel == ASEL_DIR) ? {{(ADDR_W-DATA_W){1'b0}}, dir_q} : addr_pc;
   assign bus_wdata = (cyc == CYC_WRITE) ? (data_q | mask_q) : '0;
   assign done      = last;

endmodule

// File: rtl/dbit_seq_chk.sv
module dbit_seq_chk #(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              busy,
   input logic              done,
   input logic [1:0]        bus_kind,
   input logic [ADDR_W-1:0] bus_addr
);

   assert_idle_free_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> bus_kind == 2'd0);

   assert_read_in_page_R3: assert property (@(posedge clk) disable iff (!rst_n)
      bus_kind == 2'd1 |-> bus_addr[ADDR_W-1:DATA_W] == '0);

   assert_tail_fetch_R3: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> bus_kind == 2'd3);

   assert_write_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
      bus_kind == 2'd2 |-> $past(bus_kind) == 2'd0 && $past(bus_kind, 2) == 2'd1);

   assert_five_cycles_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> busy && $past(busy, 4) && $past(bus_kind, 4) == 2'd1);

   assert_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !busy);

   assert_no_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
      busy && !done |=> busy && !$rose(bus_kind == 2'd1));

endmodule

bind dbit_seq dbit_seq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
   .clk     (clk),
   .rst_n   (rst_n),
   .busy    (busy),
   .done    (done),
   .bus_kind(bus_kind),
   .bus_addr(bus_addr)
);

// File: tb/dbit_seq_tb.sv
module dbit_seq_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [7:0]  opcode = '0;
   logic [7:0]  dir_addr = '0;
   logic [15:0] op_pc = '0;
   logic [7:0]  bus_rdata = '0;
   logic [1:0]  bus_kind;
   logic [15:0] bus_addr;
   logic [7:0]  bus_wdata;
   logic        busy, done;
   logic [15:0] next_pc;

   int checks = 0;
   int errors = 0;
   logic [7:0] mem [256];

   always #10 clk = ~clk;

   dbit_seq dut_i (
      .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode),
      .dir_addr(dir_addr), .op_pc(op_pc), .bus_rdata(bus_rdata),
      .bus_kind(bus_kind), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .busy(busy), .done(done), .next_pc(next_pc)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // 0 none, 1 branch-if-set, 2 branch-if-clear, 3 set-bit
   function automatic int kind_of(input logic [7:0] op);
      if (op[7:4] == 4'h0) return op[0] ? 2 : 1;
      if (op[7:4] == 4'h1 && !op[0]) return 3;
      return 0;
   endfunction

   function automatic logic [15:0] target(input int k, input logic [15:0] pc,
                                          input logic [7:0] rd, input logic [2:0] n,
                                          input logic [7:0] off);
      bit tk;
      if (k == 3) return pc + 16'd2;
      tk = (k == 1) ? rd[n] : !rd[n];
      return tk ? pc + 16'd3 + {{8{off[7]}}, off} : pc + 16'd3;
   endfunction

   task automatic do_instr(input logic [7:0] op, input logic [7:0] dd,
                           input logic [15:0] pc, input logic [7:0] off,
                           input bit noise);
      int          k;
      logic [7:0]  rd, ewd;
      logic [15:0] np;
      logic [1:0]  ek [5];
      logic [15:0] ea [5];
      k  = kind_of(op);
      rd = mem[dd];
      np = target(k, pc, rd, op[3:1], off);
      ewd = rd | (8'd1 << op[3:1]);
      if (k == 3) begin
         ek = '{2'd1, 2'd0, 2'd2, 2'd3, 2'd3};
         ea = '{{8'h00, dd}, 16'h0, {8'h00, dd}, pc + 16'd2, pc + 16'd3};
      end else begin
         ek = '{2'd1, 2'd3, 2'd3, 2'd3, 2'd3};
         ea = '{{8'h00, dd}, pc + 16'd2, pc + 16'd3, np, np + 16'd1};
      end
      @(negedge clk);
      start = 1'b1; opcode = op; dir_addr = dd; op_pc = pc;
      @(negedge clk);
      start = 1'b0;
      if (k == 0) begin
         chk(busy == 1'b0, "R2", "ignored opcode busy", busy, 0);
         chk(bus_kind == 2'd0, "R2", "ignored opcode bus_kind", bus_kind, 0);
         return;
      end
      for (int s = 0; s < 5; s++) begin
         if (noise && s == 1) begin
            start = 1'b1; opcode = 8'h1E; dir_addr = ~dd; op_pc = ~pc;
         end
         if (noise && s == 4) start = 1'b0;
         chk(busy == 1'b1, "R8", "busy in step", busy, 1);
         chk(done == (s == 4), "R8", "done in step", done, (s == 4));
         chk(bus_kind == ek[s], (k == 3) ? "R4" : "R3", "bus_kind", bus_kind, ek[s]);
         if (ek[s] != 2'd0)
            chk(bus_addr == ea[s], (k == 3) ? "R4" : "R3", "bus_addr", bus_addr, ea[s]);
         if (ek[s] == 2'd2) begin
            chk(bus_wdata == ewd, "R5", "write data", bus_wdata, ewd);
            mem[dd] = ewd;
         end
         if (s == 4)
            chk(next_pc == np, (k == 3) ? "R7" : "R6", "next_pc", next_pc, np);
         if (s == 0)                bus_rdata = rd;
         else if (s == 1 && k != 3) bus_rdata = off;
         else                       bus_rdata = 8'($urandom);
         @(negedge clk);
      end
      chk(busy == 1'b0, noise ? "R9" : "R8", "busy after end", busy, 0);
      chk(bus_kind == 2'd0, "R1", "bus free after end", bus_kind, 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      logic [7:0] op;
      void'($urandom(32'h1D5EED));
      for (int i = 0; i < 256; i++) mem[i] = 8'($urandom);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(busy == 1'b0, "R1", "reset busy", busy, 0);
      chk(done == 1'b0, "R1", "reset done", done, 0);
      chk(bus_kind == 2'd0, "R1", "reset bus_kind", bus_kind, 0);

      // directed corners
      mem[8'h40] = 8'h80;
      do_instr(8'h0E, 8'h40, 16'h1000, 8'h80, 0);  // R6 set form, bit7 taken, -128
      do_instr(8'h0F, 8'h40, 16'h1000, 8'h80, 0);  // R6 clear form, not taken
      mem[8'h41] = 8'h00;
      do_instr(8'h01, 8'h41, 16'h2000, 8'h7F, 0);  // R6 clear form taken, +127
      do_instr(8'h00, 8'hFF, 16'hFFFE, 8'h05, 0);  // R3 wrap of fetch addresses
      mem[8'h42] = 8'hFF;
      do_instr(8'h1C, 8'h42, 16'h3000, 8'h00, 0);  // R5 bit already set
      mem[8'h43] = 8'h00;
      do_instr(8'h10, 8'h43, 16'hFFFF, 8'h00, 0);  // R5/R7 bit0, pc wrap
      do_instr(8'h0A, 8'h44, 16'h4000, 8'h10, 1);  // R9 start during branch
      do_instr(8'h16, 8'h45, 16'h5000, 8'h00, 1);  // R9 start during set
      do_instr(8'h11, 8'h10, 16'h0100, 8'h00, 0);  // R2 odd set-group opcode
      do_instr(8'h20, 8'h10, 16'h0100, 8'h00, 0);  // R2 outside groups
      do_instr(8'hFF, 8'h10, 16'h0100, 8'h00, 0);  // R2 outside groups

      // constrained random mix
      for (int i = 0; i < 400; i++) begin
         op = ($urandom % 8 == 0) ? 8'($urandom) : {3'b000, 1'($urandom), 3'($urandom), 1'($urandom)};
         do_instr(op, 8'($urandom), 16'($urandom), 8'($urandom), ($urandom % 6) == 0);
      end

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule